// File: doc/BRIEF.md
# Segment Access Permission Checker

This block judges one memory access against one already-decoded segment descriptor. Each cycle a request may arrive carrying the descriptor (base address, 20-bit limit, access byte, two flag bits) and the access itself: a 32-bit offset, a length in bytes, a kind (read, write or instruction fetch), the current privilege level and the requested privilege level. One clock later the block reports whether the access is allowed. If it is, the block also gives the 32-bit linear address. If it is not, the block gives a fault class.

The block sits between the address-generation stage and the memory pipeline of a protected-mode core. Its limit check covers page and byte granularity, segments that grow upward and data segments that grow downward. Its rights check covers read/write permission for code and data segments. Its privilege check separates conforming code from non-conforming code. It never fetches a descriptor and never updates one.

Top module: `seg_access_checker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rsp_valid`, `rsp_ok`, `rsp_fault` and `rsp_linear` are all zero.
- R2: `rsp_valid` equals `req_valid` of the previous cycle. After a cycle with no request, `rsp_ok`, `rsp_fault` and `rsp_linear` are zero.
- R3: Granularity is `seg_flags[1]`. When it is 1, the effective limit is the limit shifted left 12 places with the low 12 bits filled with ones. When it is 0, the effective limit is the limit itself, counted in bytes.
- R4: Code segments and data segments with `seg_access[2]`=0 grow upward. For these, every byte from `req_offset` to `req_offset + req_len_m1` must be at or below the effective limit. A last byte beyond 0xFFFFFFFF is a limit fault.
- R5: A data segment with `seg_access[2]`=1 grows downward. For it, `req_offset` must be strictly above the effective limit, and the last byte must not exceed the upper bound. The upper bound is 0xFFFFFFFF when `seg_flags[0]`=1 and 0xFFFF when `seg_flags[0]`=0.
- R6: A segment with `seg_access[3]`=1 is code. A write to code is a type fault. A read from code is a type fault unless `seg_access[1]`=1. `req_type` 3 is a type fault for any segment.
- R7: A segment with `seg_access[3]`=0 is data. An instruction fetch (`req_type` 2) from data is a type fault. A write to data is a type fault unless `seg_access[1]`=1. A read from data is always allowed by type.
- R8: A descriptor with `seg_access[7]`=0 (not present) is a type fault. So is a descriptor with `seg_access[4]`=0 (system kind). `seg_access[0]` is ignored.
- R9: A fetch from non-conforming code (`seg_access[2]`=0) needs `req_cpl` equal to the privilege field `seg_access[6:5]` and `req_rpl` not above `req_cpl`. Otherwise it is a privilege fault.
- R10: A fetch from conforming code (`seg_access[2]`=1) needs `req_cpl` numerically at or above the privilege field. `req_rpl` plays no part. Otherwise it is a privilege fault.
- R11: A data access, or a read from non-conforming code, needs max(`req_cpl`, `req_rpl`) at or below the privilege field. A read from conforming code has no privilege condition.
- R12: `rsp_fault` is encoded 0 none, 1 limit, 2 type, 3 privilege. When several faults apply, type wins over privilege, and privilege wins over limit. `rsp_ok` is 1 exactly when a response is valid with fault 0.
- R13: An allowed access gives `rsp_linear` = `seg_base + req_offset` modulo 2^32. A faulting access gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| seg_base | input | 32 | Segment base linear address |
| seg_limit | input | 20 | Raw segment limit |
| seg_access | input | 8 | Access byte: 7 present, 6:5 privilege, 4 code/data kind, 3 code, 2 direction/conforming, 1 read/write enable, 0 ignored |
| seg_flags | input | 2 | Bit 1 page granularity, bit 0 big (32-bit) segment |
| req_offset | input | 32 | Offset of the first byte accessed |
| req_len_m1 | input | LEN_W (3) | Access length in bytes minus one |
| req_type | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 invalid |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Requested privilege level |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 2 | Fault class |
| rsp_linear | output | 32 | Linear address of an allowed access |

## Verification
The assertions assume that every descriptor and request field holds a known 0/1 value in any cycle where `req_valid` is high. They also assume reset is held for at least one clock before the first request. The bench drives all inputs on the falling edge and holds them for the whole cycle. It sets every field to a defined value even in idle cycles. It draws offsets close to each effective limit and upper bound, so the inverted and carry-sensitive comparisons are exercised rather than avoided.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  localparam int SEG_AW = 32;
  localparam int SEG_LW = 20;
  localparam int SEG_PG = 12;
  localparam int SMALL_TOP = 16;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_TYPE  = 2'd2,
    FLT_PRIV  = 2'd3
  } fault_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       mem_kind;
    logic       code;
    logic       dc;
    logic       rw;
  } seg_attr_t;

  function automatic seg_attr_t split_access(input logic [7:0] a);
    seg_attr_t s;
    s.present  = a[7];
    s.dpl      = a[6:5];
    s.mem_kind = a[4];
    s.code     = a[3];
    s.dc       = a[2];
    s.rw       = a[1];
    return s;
  endfunction

  // Limit expressed in bytes, whatever the granularity.
  function automatic logic [SEG_AW-1:0] scale_limit(input logic [SEG_LW-1:0] lim,
                                                    input logic page_gran);
    if (page_gran) return SEG_AW'({lim, {SEG_PG{1'b1}}});
    return SEG_AW'(lim);
  endfunction

  // Address of the final byte, one extra bit to keep the carry.
  function automatic logic [SEG_AW:0] final_byte(input logic [SEG_AW-1:0] off,
                                                 input logic [7:0] len_m1);
    return {1'b0, off} + {{(SEG_AW - 7){1'b0}}, len_m1};
  endfunction

  function automatic logic [SEG_AW-1:0] down_ceiling(input logic big);
    if (big) return {SEG_AW{1'b1}};
    return {{(SEG_AW - SMALL_TOP){1'b0}}, {SMALL_TOP{1'b1}}};
  endfunction

  function automatic logic [1:0] weaker_priv(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit
  import seg_chk_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [SEG_LW-1:0] raw_limit,
  input  logic              page_gran,
  input  logic              big_seg,
  input  logic              grows_down,
  input  logic [SEG_AW-1:0] offset,
  input  logic [LEN_W-1:0]  len_m1,
  output logic [SEG_AW-1:0] eff_limit,
  output logic              limit_bad
);

  logic [SEG_AW:0]   last_addr;
  logic [SEG_AW-1:0] ceiling;
  logic              up_bad;
  logic              below_floor;
  logic              above_ceiling;

  assign eff_limit     = scale_limit(raw_limit, page_gran);
  assign last_addr     = final_byte(offset, 8'(len_m1));
  assign ceiling       = down_ceiling(big_seg);
  assign up_bad        = last_addr > {1'b0, eff_limit};
  assign below_floor   = offset <= eff_limit;
  assign above_ceiling = last_addr > {1'b0, ceiling};
  assign limit_bad     = grows_down ? (below_floor || above_ceiling) : up_bad;

  // R5: an offset at or under the limit of a downward segment is out of range
  a_r5_down_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && grows_down && offset <= eff_limit) |-> limit_bad);

  // R3: page granularity with all-ones limit covers the full space going up
  a_r3_full_span: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !grows_down && page_gran && (&raw_limit) &&
     ({1'b0, offset} + (SEG_AW + 1)'(len_m1)) <= {1'b0, {SEG_AW{1'b1}}}) |-> !limit_bad);

  // R4: a byte-granular upward access is bounded by the raw limit value
  a_r4_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !grows_down && !page_gran && offset > SEG_AW'(raw_limit)) |-> limit_bad);

endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
  import seg_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chk_en,
  input  seg_attr_t attr,
  input  acc_kind_e kind,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  output logic      type_bad,
  output logic      priv_bad
);

  logic [1:0] eff_pl;
  logic       code_type_bad;
  logic       data_type_bad;
  logic       fetch_priv_bad;
  logic       read_priv_bad;

  assign eff_pl = weaker_priv(cpl, rpl);

  always_comb begin
    code_type_bad = 1'b0;
    case (kind)
      ACC_WRITE: code_type_bad = 1'b1;
      ACC_READ:  code_type_bad = !attr.rw;
      ACC_EXEC:  code_type_bad = 1'b0;
      default:   code_type_bad = 1'b1;
    endcase
  end

  always_comb begin
    data_type_bad = 1'b0;
    case (kind)
      ACC_WRITE: data_type_bad = !attr.rw;
      ACC_READ:  data_type_bad = 1'b0;
      default:   data_type_bad = 1'b1;
    endcase
  end

  assign type_bad = !attr.present || !attr.mem_kind ||
                    (attr.code ? code_type_bad : data_type_bad);

  assign fetch_priv_bad = attr.dc ? (cpl < attr.dpl)
                                  : ((cpl != attr.dpl) || (rpl > cpl));
  assign read_priv_bad  = (attr.code && attr.dc) ? 1'b0 : (eff_pl > attr.dpl);
  assign priv_bad       = (attr.code && kind == ACC_EXEC) ? fetch_priv_bad : read_priv_bad;

  // R6: writing code always faults by type
  a_r6_code_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && attr.code && kind == ACC_WRITE) |-> type_bad);

  // R7: fetching from data always faults by type; reading data never does
  a_r7_data_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !attr.code && kind == ACC_EXEC) |-> type_bad);
  a_r7_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && attr.present && attr.mem_kind && !attr.code && kind == ACC_READ) |-> !type_bad);

  // R8: absent descriptors fault by type
  a_r8_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !attr.present) |-> type_bad);

  // R10: conforming fetch from an equal or weaker ring is accepted
  a_r10_conf_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && attr.code && attr.dc && kind == ACC_EXEC && cpl >= attr.dpl) |-> !priv_bad);

  // R9: non-conforming fetch from another ring is refused
  a_r9_nonconf_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && attr.code && !attr.dc && kind == ACC_EXEC && cpl != attr.dpl) |-> priv_bad);

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
  import seg_chk_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       seg_base,
  input  logic [19:0]       seg_limit,
  input  logic [7:0]        seg_access,
  input  logic [1:0]        seg_flags,
  input  logic [31:0]       req_offset,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [1:0]        req_type,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_rpl,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [1:0]        rsp_fault,
  output logic [31:0]       rsp_linear
);

  localparam int FLAG_GRAN = 1;
  localparam int FLAG_BIG  = 0;

  seg_attr_t         attr;
  acc_kind_e         kind;
  logic              grows_down;
  logic              type_bad;
  logic              priv_bad;
  logic              limit_bad;
  logic [SEG_AW-1:0] eff_limit;
  logic [SEG_AW-1:0] sum_addr;
  fault_e            verdict;
  logic              unused_acc;

  assign attr       = split_access(seg_access);
  assign kind       = acc_kind_e'(req_type);
  assign grows_down = !attr.code && attr.dc;
  assign sum_addr   = seg_base + req_offset;
  assign unused_acc = seg_access[0] | (|eff_limit[0]);

  seg_rights_unit u_rights (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (req_valid),
    .attr     (attr),
    .kind     (kind),
    .cpl      (req_cpl),
    .rpl      (req_rpl),
    .type_bad (type_bad),
    .priv_bad (priv_bad)
  );

  seg_limit_unit #(.LEN_W(LEN_W)) u_limit (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (req_valid),
    .raw_limit  (seg_limit),
    .page_gran  (seg_flags[FLAG_GRAN]),
    .big_seg    (seg_flags[FLAG_BIG]),
    .grows_down (grows_down),
    .offset     (req_offset),
    .len_m1     (req_len_m1),
    .eff_limit  (eff_limit),
    .limit_bad  (limit_bad)
  );

  always_comb begin
    if (type_bad)       verdict = FLT_TYPE;
    else if (priv_bad)  verdict = FLT_PRIV;
    else if (limit_bad) verdict = FLT_LIMIT;
    else                verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_fault  <= FLT_NONE;
      rsp_linear <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok     <= (verdict == FLT_NONE);
        rsp_fault  <= verdict;
        rsp_linear <= (verdict == FLT_NONE) ? sum_addr : '0;
      end else begin
        rsp_ok     <= 1'b0;
        rsp_fault  <= FLT_NONE;
        rsp_linear <= '0;
      end
    end
  end

  // R2: one-cycle response timing
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok));

  // R12: type outranks everything else; ok only with a valid response
  a_r12_type_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && type_bad) |=> (rsp_fault == FLT_TYPE));
  a_r12_ok_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_valid && rsp_fault == FLT_NONE));

  // R13: allowed access carries base plus offset of the request cycle
  a_r13_linear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_linear == $past(seg_base + req_offset)));

endmodule

// File: tb/seg_access_checker_bench.sv
module seg_access_checker_bench;

  localparam int LEN_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [31:0]       seg_base = '0;
  logic [19:0]       seg_limit = '0;
  logic [7:0]        seg_access = '0;
  logic [1:0]        seg_flags = '0;
  logic [31:0]       req_offset = '0;
  logic [LEN_W-1:0]  req_len_m1 = '0;
  logic [1:0]        req_type = '0;
  logic [1:0]        req_cpl = '0;
  logic [1:0]        req_rpl = '0;
  logic              rsp_valid;
  logic              rsp_ok;
  logic [1:0]        rsp_fault;
  logic [31:0]       rsp_linear;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        pend_v = 0;
  logic [1:0]  pend_f = 0;
  logic [31:0] pend_a = 0;
  string       pend_tag = "R2";

  always #10 clk = ~clk;

  seg_access_checker #(.LEN_W(LEN_W)) u_seg_access_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_access(seg_access), .seg_flags(seg_flags),
    .req_offset(req_offset), .req_len_m1(req_len_m1), .req_type(req_type),
    .req_cpl(req_cpl), .req_rpl(req_rpl), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_fault(rsp_fault), .rsp_linear(rsp_linear)
  );

  function automatic logic [7:0] acc(input bit pres, input int dpl, input bit code,
                                     input bit dc, input bit rw);
    return {pres, 2'(dpl), 1'b1, code, dc, rw, 1'b0};
  endfunction

  // Behavioural reference: fault code 0 none, 1 limit, 2 type, 3 priv.
  task automatic model(output logic [1:0] f, output logic [31:0] a, output string tag);
    longint unsigned lim, last, top;
    int dpl, cpl, rpl, eff, ty;
    bit code, dc, rw;
    dpl = int'(seg_access[6:5]); code = seg_access[3]; dc = seg_access[2]; rw = seg_access[1];
    cpl = int'(req_cpl); rpl = int'(req_rpl); ty = int'(req_type);
    eff = (cpl > rpl) ? cpl : rpl;
    if (seg_flags[1]) lim = longint'(seg_limit) * 4096 + 4095;
    else lim = longint'(seg_limit);
    last = longint'(req_offset) + longint'(req_len_m1);
    top = seg_flags[0] ? 64'hFFFF_FFFF : 64'hFFFF;
    f = 0; tag = "R13";
    if (!seg_access[7] || !seg_access[4]) begin f = 2; tag = "R8"; end
    else if (ty == 3) begin f = 2; tag = "R6"; end
    else if (code && (ty == 1 || (ty == 0 && !rw))) begin f = 2; tag = "R6"; end
    else if (!code && (ty == 2 || (ty == 1 && !rw))) begin f = 2; tag = "R7"; end
    else if (code && ty == 2 && dc && cpl < dpl) begin f = 3; tag = "R10"; end
    else if (code && ty == 2 && !dc && (cpl != dpl || rpl > cpl)) begin f = 3; tag = "R9"; end
    else if (ty != 2 && !(code && dc) && eff > dpl) begin f = 3; tag = "R11"; end
    else if (!code && dc) begin
      if (longint'(req_offset) <= lim || last > top) begin f = 1; tag = "R5"; end
    end else if (last > lim) begin
      f = 1; tag = seg_flags[1] ? "R3" : "R4";
    end
    a = (f == 0) ? seg_base + req_offset : 32'h0;
  endtask

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic compare_prev();
    chk(pend_v ? pend_tag : "R2", "rsp_valid", longint'(rsp_valid), longint'(pend_v));
    chk(pend_v ? "R12" : "R2", "rsp_ok", longint'(rsp_ok),
        longint'(pend_v && pend_f == 0));
    chk(pend_v ? pend_tag : "R2", "rsp_fault", longint'(rsp_fault), longint'(pend_f));
    chk(pend_v ? "R13" : "R2", "rsp_linear", longint'(rsp_linear), longint'(pend_a));
  endtask

  // One clock: check last cycle's result, then present (or withhold) a request.
  task automatic step(input bit v, input logic [31:0] base, input logic [19:0] lim,
                      input logic [7:0] ab, input logic [1:0] fl, input logic [31:0] off,
                      input int len_m1, input int ty, input int cpl, input int rpl);
    logic [1:0] f; logic [31:0] a; string t;
    @(negedge clk);
    compare_prev();
    req_valid = v; seg_base = base; seg_limit = lim; seg_access = ab; seg_flags = fl;
    req_offset = off; req_len_m1 = LEN_W'(len_m1); req_type = 2'(ty);
    req_cpl = 2'(cpl); req_rpl = 2'(rpl);
    model(f, a, t);
    pend_v = v; pend_f = v ? f : 2'd0; pend_a = v ? a : 32'h0; pend_tag = t;
  endtask

  task automatic idle();
    step(0, 32'h0, 20'h0, 8'h0, 2'b00, 32'h0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1", "rsp_valid", longint'(rsp_valid), 0);
    chk("R1", "rsp_fault", longint'(rsp_fault), 0);
    chk("R1", "rsp_linear", longint'(rsp_linear), 0);
    rst_n = 1'b1;
    idle();
    // R3: page granularity, full span and small limit
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,1), 2'b11, 32'hFFFF_FFF8, 7, 0, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,1), 2'b11, 32'hFFFF_FFFC, 7, 0, 0, 0);
    step(1, 32'h100, 20'h00001, acc(1,0,0,0,1), 2'b11, 32'h1FFF, 0, 0, 0, 0);
    step(1, 32'h100, 20'h00001, acc(1,0,0,0,1), 2'b11, 32'h2000, 0, 0, 0, 0);
    // R4: byte granularity edge
    step(1, 32'h1000, 20'h00100, acc(1,0,0,0,1), 2'b01, 32'hFD, 3, 1, 0, 0);
    step(1, 32'h1000, 20'h00100, acc(1,0,0,0,1), 2'b01, 32'hFE, 3, 1, 0, 0);
    // R5: downward data, small and big upper bound
    step(1, 32'h0, 20'h00FFF, acc(1,0,0,1,1), 2'b00, 32'h0FFF, 0, 0, 0, 0);
    step(1, 32'h0, 20'h00FFF, acc(1,0,0,1,1), 2'b00, 32'h1000, 0, 0, 0, 0);
    step(1, 32'h0, 20'h00FFF, acc(1,0,0,1,1), 2'b00, 32'hFFFC, 3, 0, 0, 0);
    step(1, 32'h0, 20'h00FFF, acc(1,0,0,1,1), 2'b00, 32'hFFFD, 3, 0, 0, 0);
    step(1, 32'h0, 20'h00FFF, acc(1,0,0,1,1), 2'b01, 32'hFFFF_FFFC, 3, 0, 0, 0);
    // R6: code rights
    step(1, 32'h0, 20'hFFFFF, acc(1,0,1,0,1), 2'b11, 32'h10, 0, 1, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,1,0,0), 2'b11, 32'h10, 0, 0, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,1,0,1), 2'b11, 32'h10, 0, 0, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,1), 2'b11, 32'h10, 0, 3, 0, 0);
    // R7: data rights
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,1), 2'b11, 32'h10, 0, 2, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,0), 2'b11, 32'h10, 0, 1, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,0), 2'b11, 32'h10, 0, 0, 0, 0);
    // R8: not present, system kind
    step(1, 32'h0, 20'hFFFFF, acc(0,0,0,0,1), 2'b11, 32'h10, 0, 0, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,0,0,1) & 8'hEF, 2'b11, 32'h10, 0, 0, 0, 0);
    // R9: non-conforming fetch
    step(1, 32'h0, 20'hFFFFF, acc(1,2,1,0,0), 2'b11, 32'h10, 0, 2, 2, 2);
    step(1, 32'h0, 20'hFFFFF, acc(1,2,1,0,0), 2'b11, 32'h10, 0, 2, 3, 3);
    step(1, 32'h0, 20'hFFFFF, acc(1,2,1,0,0), 2'b11, 32'h10, 0, 2, 2, 3);
    // R10: conforming fetch
    step(1, 32'h0, 20'hFFFFF, acc(1,1,1,1,0), 2'b11, 32'h10, 0, 2, 3, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,1,1,1,0), 2'b11, 32'h10, 0, 2, 0, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,1,1,1,0), 2'b11, 32'h10, 0, 2, 1, 3);
    // R11: data privilege uses the weaker of cpl and rpl
    step(1, 32'h0, 20'hFFFFF, acc(1,2,0,0,1), 2'b11, 32'h10, 0, 0, 2, 3);
    step(1, 32'h0, 20'hFFFFF, acc(1,2,0,0,1), 2'b11, 32'h10, 0, 1, 1, 0);
    step(1, 32'h0, 20'hFFFFF, acc(1,0,1,1,1), 2'b11, 32'h10, 0, 0, 3, 3);
    // R12: priority between fault classes
    step(1, 32'h0, 20'h00010, acc(1,0,1,0,1), 2'b00, 32'h100, 0, 1, 3, 3);
    step(1, 32'h0, 20'h00010, acc(1,0,0,0,1), 2'b00, 32'h100, 0, 0, 3, 3);
    // R13: wrapping linear sum
    step(1, 32'hFFFF_F000, 20'hFFFFF, acc(1,3,0,0,1), 2'b11, 32'h2000, 1, 0, 3, 3);
    idle(); idle();
    // Mixed stream with offsets clustered near each bound
    for (int i = 0; i < 4000; i++) begin
      logic [19:0] lim; logic [1:0] fl; logic [7:0] ab; logic [31:0] off;
      longint unsigned el; int pick;
      fl = 2'($urandom);
      pick = int'($urandom % 3);
      lim = (pick == 0) ? 20'($urandom % 256) : (pick == 1) ? 20'hFFFFF : 20'($urandom);
      ab = {($urandom % 8) != 0, 2'($urandom), ($urandom % 8) != 0, 4'($urandom), 1'($urandom)};
      el = fl[1] ? longint'(lim) * 4096 + 4095 : longint'(lim);
      pick = int'($urandom % 4);
      if (pick == 0) off = 32'(el) + 32'($urandom % 16) - 32'd8;
      else if (pick == 1) off = (fl[0] ? 32'hFFFF_FFFF : 32'hFFFF) - 32'($urandom % 12);
      else off = $urandom;
      if ($urandom % 5 == 0) idle();
      step(1, $urandom, lim, ab, fl, off, int'($urandom % 8), int'($urandom % 4),
           int'($urandom % 4), int'($urandom % 4));
    end
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule